// File: doc/BRIEF.md
# Address-Triggered Mask Fault Injector

This block sits on the data path into a register or memory word and corrupts that word on purpose, so that error detection and recovery logic can be tested. Before an experiment, the controlling side writes the block's settings. These are the bus address to watch, a countdown value, a bit mask, a corruption operation and a persistence mode. The controller then arms the block. While it is armed, an access to the watched address, or the end of the countdown, triggers the block. On a trigger, the data word passing through is altered in the same cycle. Only the bits selected by the mask are altered.

The data path is purely combinational, so the block adds no cycle of latency. The block only modifies data while it is armed and a trigger is active. At all other times `data_o` is exactly `data_i`. A pulse output marks each corrupted cycle, and a sticky flag records that at least one fault has been applied since the last arm.

Top module: `addr_fault_injector`

## Requirements
- R1: While the block injects, only the bits that are 1 in the stored mask may differ between `data_o` and `data_i`. Every other bit passes unchanged. When the block does not inject, `data_o` equals `data_i`.
- R2: The operation field `cfg_op_i` has four codes. Code 0 forces the masked bits to 0. Code 1 forces them to 1. Code 2 inverts them.
- R3: Code 3 of `cfg_op_i` is bridging. Each masked bit i takes the value of input bit i-1, and a masked bit 0 takes the value of input bit DW-1.
- R4: While armed, a cycle with `bus_valid_i` high and `bus_addr_i` equal to the stored trigger address is corrupted in that same cycle. An access to any other address passes untouched.
- R5: Arming loads the countdown from the stored timeout value T. If T is not zero, the counter reaches zero T cycles after the arming edge. From that cycle on, each cycle counts as a trigger whether or not a bus access is present.
- R6: A stored timeout of zero disables the timer trigger. Only address matches can then fire.
- R7: In transient mode (`cfg_permanent_i` = 0), the first triggered cycle is the only one corrupted. The block then disarms itself on the following edge.
- R8: In permanent mode, every triggered cycle is corrupted and the block stays armed until `disarm_i` is pulsed.
- R9: `injected_o` is high exactly in the cycles where corrupted data is driven. `fault_seen_o` goes high after the first such cycle and stays high until the next accepted arm, which clears it.
- R10: A configuration write (`cfg_we_i`) while the block is armed is ignored, and injection keeps using the earlier settings. An arm request while already armed is also ignored.
- R11: After reset the block is disarmed, `injected_o` and `fault_seen_o` are low, and data passes unchanged.
- R12: When `arm_i` and `disarm_i` are high in the same cycle, disarm wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write the configuration fields below (ignored while armed) |
| cfg_addr_i | input | AW | Trigger address |
| cfg_timeout_i | input | TW | Countdown load value, 0 disables the timer |
| cfg_mask_i | input | DW | Bits allowed to be corrupted |
| cfg_op_i | input | 2 | 0 stuck-at-0, 1 stuck-at-1, 2 flip, 3 bridge |
| cfg_permanent_i | input | 1 | 1 permanent, 0 transient (one shot) |
| arm_i | input | 1 | Arm request pulse |
| disarm_i | input | 1 | Disarm pulse, wins over arm |
| bus_valid_i | input | 1 | Bus access present this cycle |
| bus_addr_i | input | AW | Address of the current access |
| data_i | input | DW | Word on its way to the target |
| data_o | output | DW | Word delivered to the target, possibly corrupted |
| injected_o | output | 1 | High in each cycle corrupted data is driven |
| armed_o | output | 1 | Block is armed |
| fault_seen_o | output | 1 | Sticky: a fault has been applied since the last arm |

## Verification
Each of the four operations is applied to a word of mixed ones and zeros under a mask that covers only part of the word. An inverting operation cannot then pass for a forcing one. The mask reaches bit 0 and the top bit, so the bridging wraparound shows up. Accesses to a neighbouring address, access bursts in transient and in permanent mode, and timer runs with a short and a zero load value are used to separate the two trigger sources and the two persistence modes. Configuration writes and arm requests issued while armed, and an arm pulse that collides with a disarm pulse, check that the settings stay locked and that disarm takes priority.

// File: rtl/addr_fault_injector.sv
module addr_fault_injector #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [TW-1:0] cfg_timeout_i,
  input  logic [DW-1:0] cfg_mask_i,
  input  logic [1:0]    cfg_op_i,
  input  logic          cfg_permanent_i,
  input  logic          arm_i,
  input  logic          disarm_i,
  input  logic          bus_valid_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          injected_o,
  output logic          armed_o,
  output logic          fault_seen_o
);
  logic [AW-1:0] trig_q;
  logic [TW-1:0] tmo_q, cnt_q;
  logic [DW-1:0] mask_q, bad;
  logic [1:0]    op_q;
  logic          perm_q, armed_q, tmr_en_q, seen_q;

  wire addr_hit = armed_q & bus_valid_i & (bus_addr_i == trig_q);
  wire tmr_hit  = armed_q & tmr_en_q & (cnt_q == '0);
  wire fire     = addr_hit | tmr_hit;
  wire arm_ok   = arm_i & ~armed_q & ~disarm_i;
  wire [DW-1:0] rot = {data_i[DW-2:0], data_i[DW-1]};

  always_comb begin
    case (op_q)
      2'd0: bad = data_i & ~mask_q;
      2'd1: bad = data_i | mask_q;
      2'd2: bad = data_i ^ mask_q;
      2'd3: bad = (data_i & ~mask_q) | (rot & mask_q);
    endcase
  end

  assign data_o       = fire ? bad : data_i;
  assign injected_o   = fire;
  assign armed_o      = armed_q;
  assign fault_seen_o = seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      tmo_q  <= '0;
      mask_q <= '0;
      op_q   <= '0;
      perm_q <= 1'b0;
    end else if (cfg_we_i && !armed_q) begin
      trig_q <= cfg_addr_i;
      tmo_q  <= cfg_timeout_i;
      mask_q <= cfg_mask_i;
      op_q   <= cfg_op_i;
      perm_q <= cfg_permanent_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      tmr_en_q <= 1'b0;
      cnt_q    <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (disarm_i)
        armed_q <= 1'b0;
      else if (arm_ok)
        armed_q <= 1'b1;
      else if (fire && !perm_q)
        armed_q <= 1'b0;

      if (arm_ok) begin
        cnt_q    <= tmo_q;
        tmr_en_q <= (tmo_q != '0);
      end else if (armed_q && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end

      if (fire)
        seen_q <= 1'b1;
      else if (arm_ok)
        seen_q <= 1'b0;
    end
  end
endmodule

module addr_fault_injector_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] data_i,
  input logic [DW-1:0] data_o,
  input logic [DW-1:0] mask_q,
  input logic          injected_o,
  input logic          armed_o,
  input logic          fault_seen_o,
  input logic          perm_q,
  input logic          disarm_i,
  input logic          cfg_we_i
);
  p_mask_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_o ^ data_i) & ~mask_q) == '0);
  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !injected_o |-> data_o == data_i);
  p_inject_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    injected_o |-> armed_o);
  p_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    injected_o && !perm_q |=> !armed_o);
  p_perm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o && perm_q && !disarm_i |=> armed_o);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    injected_o |=> fault_seen_o);
  p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o && cfg_we_i |=> $stable(mask_q));
  p_disarm_r12: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> !armed_o);
endmodule

bind addr_fault_injector addr_fault_injector_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_i(data_i), .data_o(data_o), .mask_q(mask_q),
  .injected_o(injected_o), .armed_o(armed_o), .fault_seen_o(fault_seen_o),
  .perm_q(perm_q), .disarm_i(disarm_i), .cfg_we_i(cfg_we_i)
);

// File: tb/addr_fault_injector_bench.sv
module addr_fault_injector_bench;
  localparam int DW = 32, AW = 16, TW = 16;
  localparam logic [AW-1:0] TA = 16'h1234;
  localparam logic [DW-1:0] MSK = 32'h8000_F0F1;
  localparam logic [DW-1:0] DAT = 32'h3C5A_96A5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we_i = 0, cfg_permanent_i = 0, arm_i = 0, disarm_i = 0, bus_valid_i = 0;
  logic [AW-1:0] cfg_addr_i = '0, bus_addr_i = '0;
  logic [TW-1:0] cfg_timeout_i = '0;
  logic [DW-1:0] cfg_mask_i = '0, data_i = '0, data_o;
  logic [1:0] cfg_op_i = '0;
  logic injected_o, armed_o, fault_seen_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  addr_fault_injector #(.DW(DW), .AW(AW), .TW(TW)) u_addr_fault_injector (.*);

  function automatic logic [DW-1:0] model(logic [DW-1:0] d, logic [DW-1:0] m, logic [1:0] op);
    logic [DW-1:0] r = d;
    for (int i = 0; i < DW; i++)
      if (m[i])
        case (op)
          2'd0: r[i] = 1'b0;
          2'd1: r[i] = 1'b1;
          2'd2: r[i] = ~d[i];
          2'd3: r[i] = d[(i + DW - 1) % DW];
        endcase
    return r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic configure(logic [AW-1:0] a, logic [TW-1:0] t, logic [DW-1:0] m, logic [1:0] op, logic perm);
    @(negedge clk);
    cfg_we_i = 1; cfg_addr_i = a; cfg_timeout_i = t; cfg_mask_i = m; cfg_op_i = op; cfg_permanent_i = perm;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic arm();
    @(negedge clk); arm_i = 1;
    @(negedge clk); arm_i = 0;
  endtask

  task automatic access(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_valid_i = 1; bus_addr_i = a; data_i = d;
    #2;
  endtask

  task automatic idle();
    @(negedge clk); bus_valid_i = 0; #2;
  endtask

  task automatic t_reset();
    data_i = DAT; #2;
    chk("R11 armed", armed_o, 0);
    chk("R11 injected", injected_o, 0);
    chk("R11 seen", fault_seen_o, 0);
    chk("R11 data", data_o, DAT);
  endtask

  task automatic t_ops();
    for (int op = 0; op < 4; op++) begin
      configure(TA, '0, MSK, op[1:0], 1'b0);
      arm();
      chk("R9 seen cleared on arm", fault_seen_o, 0);
      access(TA + 1, DAT);
      chk("R4 other address", data_o, DAT);
      chk("R4 other address inj", injected_o, 0);
      access(TA, DAT);
      chk(op == 3 ? "R3 bridge" : "R2 op", data_o, model(DAT, MSK, op[1:0]));
      chk("R9 injected pulse", injected_o, 1);
      access(TA, DAT);
      chk("R7 one shot data", data_o, DAT);
      chk("R7 disarmed", armed_o, 0);
      chk("R9 sticky", fault_seen_o, 1);
      idle();
    end
  endtask

  task automatic t_timer();
    configure(TA, 16'd5, MSK, 2'd2, 1'b0);
    data_i = DAT;
    arm();
    #2;
    for (int j = 0; j < 5; j++) begin
      chk("R5 before expiry", injected_o, 0);
      @(negedge clk); #2;
    end
    chk("R5 expiry inject", injected_o, 1);
    chk("R5 expiry data", data_o, model(DAT, MSK, 2'd2));
    @(negedge clk); #2;
    chk("R7 timer one shot", injected_o, 0);
    chk("R7 timer disarm", armed_o, 0);
  endtask

  task automatic t_timeout0();
    int hits = 0;
    configure(TA, '0, MSK, 2'd1, 1'b0);
    arm();
    for (int j = 0; j < 40; j++) begin
      @(negedge clk); #2;
      if (injected_o) hits++;
    end
    chk("R6 no timer fire", hits, 0);
    chk("R6 still armed", armed_o, 1);
    @(negedge clk); disarm_i = 1; @(negedge clk); disarm_i = 0;
  endtask

  task automatic t_perm();
    configure(TA, '0, MSK, 2'd1, 1'b1);
    arm();
    for (int j = 0; j < 3; j++) begin
      access(TA, DAT ^ j);
      chk("R8 repeat corrupt", data_o, model(DAT ^ j, MSK, 2'd1));
    end
    idle();
    chk("R8 stays armed", armed_o, 1);
    @(negedge clk); disarm_i = 1; @(negedge clk); disarm_i = 0;
    access(TA, DAT);
    chk("R8 after disarm", data_o, DAT);
    idle();
  endtask

  task automatic t_cfg_lock();
    configure(TA, '0, MSK, 2'd2, 1'b1);
    arm();
    configure(TA + 2, '0, 32'hFFFF_FFFF, 2'd0, 1'b0);
    access(TA + 2, DAT);
    chk("R10 new address ignored", data_o, DAT);
    access(TA, DAT);
    chk("R10 old settings used", data_o, model(DAT, MSK, 2'd2));
    idle();
    arm();
    chk("R10 arm while armed keeps sticky", fault_seen_o, 1);
    @(negedge clk); arm_i = 1; disarm_i = 1;
    @(negedge clk); arm_i = 0; disarm_i = 0; #2;
    chk("R12 disarm wins", armed_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ops();
    t_timer();
    t_timeout0();
    t_perm();
    t_cfg_lock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule